// File: doc/BRIEF.md
# Module Status Flag Interrupt Controller

This block keeps the sticky status flags of a pluggable optical module's management interface and drives its active-low interrupt pin. Raw condition lines (transmit fault, loss and alarm events) pass through a synchroniser. Each line then latches a flag bit that holds until the two-wire serial slave reports that a read of the byte holding it has completed. Each flag has a mask bit that keeps it from raising the interrupt. The pin either stays low while any unmasked flag is pending (static mode, the default) or gives a fixed-width low pulse when the pending set goes from empty to non-empty (pulse mode).

After reset is released, a start-up counter keeps the module in a not-ready state. In that state the Data Not Ready bit reads 1, the transmit and receive enables are off and the serial slave is told to stay silent. When the counter expires, Data Not Ready clears and a ready event is raised on the interrupt pin. A read of the status byte at address 2 (bit 0 holds Data Not Ready) acknowledges that event. Flag byte k sits at address FLAG_BASE_ADDR + k. Bit i of `flags_o` lives in byte i/8, bit i%8, and bit 0 is the transmit-fault flag.

Top module: `modflag_irq_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, on the next edge all flags go to 0, `dnr_o` goes to 1, `intl_n_o` goes to 1, `tx_en_o` and `rx_en_o` go to 0, `slave_quiet_o` goes to 1 and the interrupt mode returns to static.
- R2: Ready is reached on exactly the INIT_CYCLES-th clock edge with `rst_n` high after reset. From that edge on, `dnr_o` is 0, both enables are 1 and `slave_quiet_o` is 0. Before it, they keep their R1 values.
- R3: On the edge where ready is reached, a ready event becomes pending. It drives the interrupt like an unmasked flag. Only a completed read (`rd_done_i`=1) with `rd_addr_i`=2 clears it.
- R4: A condition bit `cond_i[i]` that is 1 while the block is ready sets `flags_o[i]` SYNC_STAGES+1 edges after it is sampled. `cond_i[0]` is the transmit fault. Conditions that reach the flag stage before ready have no effect.
- R5: A set flag stays 1 when its condition goes away, until a clearing read of its byte.
- R6: A completed read at address FLAG_BASE_ADDR+k clears only the eight flags of byte k on the next edge. Reads at any other address leave all flags unchanged.
- R7: If a flag's synchronised condition is still 1 on the clearing edge, the flag reads 0 for one cycle and is set again on the following edge.
- R8: A flag whose `mask_i` bit is 1 does not drive the interrupt. Clearing the mask bit lets a pending flag drive it again one edge later.
- R9: In static mode, `intl_n_o` is the inverse of "ready and (any flag and not mask, or ready event pending)", registered one edge later.
- R10: In pulse mode, a rise of that pending term drives `intl_n_o` low for exactly PULSE_CYCLES cycles. While the term stays high, no further pulse occurs.
- R11: `pulse_mode_i` takes effect one edge after it is sampled (1 = pulse, 0 = static).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 8*FLAG_BYTES | Raw asynchronous condition lines, bit 0 transmit fault |
| mask_i | input | 8*FLAG_BYTES | Per-flag interrupt mask, 1 inhibits |
| pulse_mode_i | input | 1 | Interrupt mode select, 1 pulse, 0 static |
| rd_done_i | input | 1 | One-cycle strobe: serial read transaction completed |
| rd_addr_i | input | 8 | Byte address covered by the completed read |
| flags_o | output | 8*FLAG_BYTES | Latched flag bits |
| dnr_o | output | 1 | Data Not Ready status bit |
| intl_n_o | output | 1 | Active-low interrupt pin |
| tx_en_o | output | 1 | Transmit output enable |
| rx_en_o | output | 1 | Receive output enable |
| slave_quiet_o | output | 1 | Tells the serial slave not to respond |

## Verification
Two things can fall in the same cycle: a clear-on-read of a byte and a still-active condition in that byte. A condition line is held high across a read of its own byte, and the flag is expected to drop for one cycle and come back. In the same way, a mask change, a mode change and a pending-term rise can meet on one edge. The randomised phase throws all of these at each other. A behavioural reference model compares every output on every clock, so the outcome on each such edge is judged against the requirements.

// File: rtl/modflag_pkg.sv
// Shared types for the status flag interrupt controller.
package modflag_pkg;
    typedef enum logic {
        IRQ_STATIC = 1'b0,
        IRQ_PULSE  = 1'b1
    } irq_mode_e;

    localparam int ADDR_W = 8;
endpackage

// File: rtl/modflag_sync.sv
// Multi-stage synchroniser for the raw condition lines.
// Assumes every input bit is independent; no bus coherency is needed.
module modflag_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[0] <= '0;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modflag_init.sv
// Start-up sequencer: counts INIT_CYCLES after reset, then raises ready
// and a pending ready event that a read of the status byte acknowledges.
// Assumes INIT_CYCLES >= 1.
module modflag_init #(
    parameter int INIT_CYCLES = 20,
    parameter int STATUS_ADDR = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_done_i,
    input  logic [modflag_pkg::ADDR_W-1:0] rd_addr_i,
    output logic                       ready_o,
    output logic                       pend_o
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          ready_q;
    logic          pend_q;
    logic          ack;

    assign ack = rd_done_i && (rd_addr_i == modflag_pkg::ADDR_W'(STATUS_ADDR));

    // Count the start-up delay and raise ready when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) ready_q <= 1'b1;
        end
    end

    // Ready event: set with ready, cleared by a status byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend_q <= 1'b0;
        else if (!ready_q && cnt_q == LAST)  pend_q <= 1'b1;
        else if (ack)                        pend_q <= 1'b0;
    end

    assign ready_o = ready_q;
    assign pend_o  = pend_q;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!ready_q && !pend_q));

    p_init_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_q && cnt_q < LAST) |=> !ready_q);

    p_ready_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> pend_q);
endmodule

// File: rtl/modflag_flagbank.sv
// Sticky flag register bank. Flags set from synchronised conditions while
// ready and clear per byte on a completed read of that byte. Clear wins on
// the clearing edge, so a persisting condition re-sets the flag one edge later.
module modflag_flagbank #(
    parameter int NBYTES    = 2,
    parameter int BASE_ADDR = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ready_i,
    input  logic [8*NBYTES-1:0]            cond_s_i,
    input  logic                           rd_done_i,
    input  logic [modflag_pkg::ADDR_W-1:0] rd_addr_i,
    output logic [8*NBYTES-1:0]            flags_o
);
    localparam int NF = 8 * NBYTES;

    logic [NF-1:0] flags_q;
    logic [NF-1:0] clr_v;
    logic [NF-1:0] keep_v;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Byte b is cleared when the completed read addresses it.
        assign clr_v[8*b +: 8] =
            {8{rd_done_i && (rd_addr_i == modflag_pkg::ADDR_W'(BASE_ADDR + b))}};
    end

    assign keep_v = flags_q & ~clr_v;

    // Latch new conditions, drop cleared bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (ready_i)  flags_q <= (flags_q | cond_s_i) & ~clr_v;
        else               flags_q <= '0;
    end

    assign flags_o = flags_q;

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> ((flags_q & $past(keep_v)) == $past(keep_v)));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_v) |=> ((flags_q & $past(clr_v)) == '0));
endmodule

// File: rtl/modflag_irq.sv
// Interrupt pin generator. Forms the pending term from unmasked flags and
// the ready event, then drives the pin as a static level or a fixed pulse.
// Assumes PULSE_CYCLES >= 1.
module modflag_irq #(
    parameter int NF           = 16,
    parameter int PULSE_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready_i,
    input  logic          pend_i,
    input  logic [NF-1:0] flags_i,
    input  logic [NF-1:0] mask_i,
    input  logic          pulse_mode_i,
    output logic          intl_n_o
);
    import modflag_pkg::*;

    localparam int PW = $clog2(PULSE_CYCLES + 1);

    irq_mode_e     mode_q;
    logic          irq_any;
    logic          prev_q;
    logic          stat_q;
    logic [PW-1:0] pcnt_q;

    assign irq_any = ready_i && ((|(flags_i & ~mask_i)) || pend_i);

    // Register the mode select; static after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= IRQ_STATIC;
        else        mode_q <= pulse_mode_i ? IRQ_PULSE : IRQ_STATIC;
    end

    // Static level and rise detector for the pending term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b1;
            prev_q <= 1'b0;
        end else begin
            stat_q <= !irq_any;
            prev_q <= irq_any;
        end
    end

    // Pulse width counter, loaded on every rise of the pending term.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pcnt_q <= '0;
        else if (irq_any && !prev_q) pcnt_q <= PW'(PULSE_CYCLES);
        else if (pcnt_q != '0)       pcnt_q <= pcnt_q - 1'b1;
    end

    assign intl_n_o = (mode_q == IRQ_PULSE) ? (pcnt_q == '0) : stat_q;

    p_static_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mode_q == IRQ_PULSE) || (intl_n_o == !$past(irq_any))));

    p_pulse_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any && !prev_q) |=> (pcnt_q == PW'(PULSE_CYCLES)));

    p_quiet_unready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> intl_n_o);
endmodule

// File: rtl/modflag_irq_ctrl.sv
// Top of the status flag interrupt controller. Chains the condition
// synchroniser, the flag bank, the start-up sequencer and the pin generator.
// Assumes rd_done_i is a one-cycle strobe from the serial slave.
module modflag_irq_ctrl #(
    parameter int FLAG_BYTES     = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int INIT_CYCLES    = 20,
    parameter int PULSE_CYCLES   = 4,
    parameter int FLAG_BASE_ADDR = 3,
    parameter int STATUS_ADDR    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*FLAG_BYTES-1:0] cond_i,
    input  logic [8*FLAG_BYTES-1:0] mask_i,
    input  logic                    pulse_mode_i,
    input  logic                    rd_done_i,
    input  logic [7:0]              rd_addr_i,
    output logic [8*FLAG_BYTES-1:0] flags_o,
    output logic                    dnr_o,
    output logic                    intl_n_o,
    output logic                    tx_en_o,
    output logic                    rx_en_o,
    output logic                    slave_quiet_o
);
    localparam int NF = 8 * FLAG_BYTES;

    logic [NF-1:0] cond_s;
    logic [NF-1:0] flags;
    logic          ready;
    logic          pend;

    modflag_sync #(.W(NF), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cond_i),
        .q_o   (cond_s)
    );

    modflag_init #(.INIT_CYCLES(INIT_CYCLES), .STATUS_ADDR(STATUS_ADDR)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_done_i (rd_done_i),
        .rd_addr_i (rd_addr_i),
        .ready_o   (ready),
        .pend_o    (pend)
    );

    modflag_flagbank #(.NBYTES(FLAG_BYTES), .BASE_ADDR(FLAG_BASE_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready),
        .cond_s_i  (cond_s),
        .rd_done_i (rd_done_i),
        .rd_addr_i (rd_addr_i),
        .flags_o   (flags)
    );

    modflag_irq #(.NF(NF), .PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_i      (ready),
        .pend_i       (pend),
        .flags_i      (flags),
        .mask_i       (mask_i),
        .pulse_mode_i (pulse_mode_i),
        .intl_n_o     (intl_n_o)
    );

    assign flags_o       = flags;
    assign dnr_o         = !ready;
    assign tx_en_o       = ready;
    assign rx_en_o       = ready;
    assign slave_quiet_o = !ready;

    p_enables_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o == rx_en_o) && (tx_en_o != dnr_o) && (slave_quiet_o == dnr_o));
endmodule

// File: tb/modflag_irq_ctrl_tb.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with every output 1 ns later. Inputs change on falling edges.
module modflag_irq_ctrl_tb_top;
    localparam int FB    = 2;
    localparam int NF    = 8 * FB;
    localparam int SYNC  = 2;
    localparam int INIT  = 20;
    localparam int PULSE = 4;
    localparam int BASE  = 3;
    localparam int STAT  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] cond = '0;
    logic [NF-1:0] mask = '0;
    logic          pmode = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    raddr = '0;

    logic [NF-1:0] flags_o;
    logic dnr_o, intl_n_o, tx_en_o, rx_en_o, quiet_o;

    int    vectors = 0;
    int    fails = 0;
    string phase = "R1";

    always #2 clk = ~clk;  // 250 MHz

    modflag_irq_ctrl #(
        .FLAG_BYTES(FB), .SYNC_STAGES(SYNC), .INIT_CYCLES(INIT),
        .PULSE_CYCLES(PULSE), .FLAG_BASE_ADDR(BASE), .STATUS_ADDR(STAT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .mask_i(mask),
        .pulse_mode_i(pmode), .rd_done_i(rd), .rd_addr_i(raddr),
        .flags_o(flags_o), .dnr_o(dnr_o), .intl_n_o(intl_n_o),
        .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .slave_quiet_o(quiet_o)
    );

    // Reference model state.
    logic [NF-1:0] sq [$];
    logic [NF-1:0] m_flags = '0;
    bit  m_ready = 0, m_pend = 0, m_mode = 0, m_prev = 0, m_stat = 1;
    int  m_cnt = 0, m_pcnt = 0;

    always @(posedge clk) begin
        logic [NF-1:0] s;
        logic [NF-1:0] clr;
        bit any;
        any = m_ready && ((|(m_flags & ~mask)) || m_pend);
        if (!rst_n) begin
            sq.delete();
            for (int i = 0; i < SYNC; i++) sq.push_back('0);
            m_flags = '0; m_ready = 0; m_pend = 0; m_mode = 0;
            m_prev = 0; m_stat = 1; m_cnt = 0; m_pcnt = 0;
        end else begin
            s = sq.pop_front();
            sq.push_back(cond);
            clr = '0;
            for (int b = 0; b < FB; b++)
                if (rd && raddr == 8'(BASE + b)) clr[8*b +: 8] = 8'hFF;
            // Pulse counter and level use the pending term before this edge.
            if (any && !m_prev) m_pcnt = PULSE;
            else if (m_pcnt > 0) m_pcnt = m_pcnt - 1;
            m_prev = any;
            m_stat = !any;
            m_mode = pmode;
            m_flags = m_ready ? ((m_flags | s) & ~clr) : '0;
            if (!m_ready) begin
                if (m_cnt == INIT - 1) begin m_ready = 1; m_pend = 1; end
                m_cnt++;
            end else if (rd && raddr == 8'(STAT)) m_pend = 0;
        end
    end

    task automatic cmp1(string what, logic [NF-1:0] act, logic [NF-1:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h @%0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare every output after each edge.
    always @(posedge clk) begin
        #1;
        vectors++;
        cmp1("flags_o (R4/R5/R6/R7)", flags_o, m_flags);
        cmp1("dnr_o (R2)", NF'(dnr_o), NF'(!m_ready));
        cmp1("tx_en_o (R2)", NF'(tx_en_o), NF'(m_ready));
        cmp1("rx_en_o (R2)", NF'(rx_en_o), NF'(m_ready));
        cmp1("slave_quiet_o (R1)", NF'(quiet_o), NF'(!m_ready));
        cmp1("intl_n_o (R9/R10)", NF'(intl_n_o), NF'(m_mode ? (m_pcnt == 0) : m_stat));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_byte(logic [7:0] a);
        @(negedge clk); rd = 1'b1; raddr = a;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulse_cond(int bitn);
        @(negedge clk); cond[bitn] = 1'b1;
        @(negedge clk); cond[bitn] = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, with pulse mode requested during reset.
        phase = "R1"; pmode = 1'b1; cond = '1;
        cyc(5);
        phase = "R2"; pmode = 1'b0; cond = '0;
        rst_n = 1'b1;
        // R2: start-up window, conditions before ready are ignored (R4).
        cyc(5); cond[2] = 1'b1; cyc(3); cond[2] = 1'b0;
        cyc(INIT);
        // R3: ready event holds the pin low until a status byte read.
        phase = "R3"; cyc(4); rd_byte(8'(STAT)); cyc(3);
        // R4: transmit fault latches.
        phase = "R4"; pulse_cond(0); cyc(6);
        // R5: sticky, R6: reads of other addresses do not clear.
        phase = "R5"; cyc(8);
        phase = "R6"; rd_byte(8'(BASE + 1)); rd_byte(8'd9); rd_byte(8'(STAT));
        cyc(2); rd_byte(8'(BASE)); cyc(3);
        // R7: condition still present on the clearing edge.
        phase = "R7"; @(negedge clk); cond[9] = 1'b1; cyc(6);
        rd_byte(8'(BASE + 1)); cyc(3); cond[9] = 1'b0; cyc(4);
        rd_byte(8'(BASE + 1)); cyc(3);
        // R8: masked flag stays quiet, unmasking restores the pin.
        phase = "R8"; mask[3] = 1'b1; pulse_cond(3); cyc(8);
        @(negedge clk); mask[3] = 1'b0; cyc(4); rd_byte(8'(BASE)); cyc(3);
        // R11 and R10: pulse mode, no second pulse while pending stays high.
        phase = "R11"; @(negedge clk); pmode = 1'b1; cyc(2);
        phase = "R10"; pulse_cond(5); cyc(10); pulse_cond(6); cyc(10);
        rd_byte(8'(BASE)); cyc(3); pulse_cond(12); cyc(8);
        phase = "R11"; @(negedge clk); pmode = 1'b0; cyc(4);
        rd_byte(8'(BASE + 1)); cyc(3);
        // R9: randomised mix of conditions, masks, reads and mode changes.
        phase = "R9";
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            cond = ($urandom % 6 == 0) ? NF'(1) << ($urandom % NF) : '0;
            if ($urandom % 20 == 0) mask = NF'($urandom);
            if ($urandom % 60 == 0) pmode = ~pmode;
            rd = ($urandom % 5 == 0);
            raddr = 8'(2 + ($urandom % 4));
        end
        @(negedge clk); rd = 1'b0; cond = '0;
        // R1 again: reset in mid-operation.
        phase = "R1"; rst_n = 1'b0; cyc(3); rst_n = 1'b1;
        phase = "R2"; cyc(INIT + 5);
        summary();
        $finish;
    end
endmodule